// File: doc/BRIEF.md
# SIMT Branch Reconvergence Stack

This block steers one warp of scalar threads that run in lockstep from a shared program counter. It keeps a small stack of control records. Each record holds three values: the PC at which a group of threads merges again, the PC that the group runs next, and a mask of the threads in that group. The record on top of the stack supplies the warp's current PC and active mask.

Each retired instruction is reported with a step strobe. For a branch, the step also carries each thread's direction, the taken target, the fall-through PC and the merge PC. Sometimes the active threads do not all agree on the direction. In that case the block parks the current record at the merge PC and pushes two new records: the not-taken group first, then the taken group. The taken group therefore runs first. When the running group's next PC reaches its merge PC, the record is dropped. Execution then continues with the wider group beneath it, and one bubble cycle marks the drop.

The bottom record is created at reset with every thread active and an all-ones merge PC, which can never be reached. A divergent branch that finds too little room for two more records sets a sticky error flag and leaves the stack untouched.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, pc_o equals RESET_PC, mask_o is all ones, depth_o is 1, overflow_o is 0 and pc_valid_o is 1.
- R2: An accepted step with is_branch_i low advances pc_o by one on the next cycle and keeps mask_o and depth_o.
- R3: On an accepted branch, taken_i bits of inactive threads are ignored. If every active thread is taken, pc_o becomes taken_pc_i. If none is taken, pc_o becomes fall_pc_i. Mask and depth are unchanged in both cases.
- R4: An accepted branch whose active threads disagree raises depth_o by 2. The next cycle shows pc_o = taken_pc_i and mask_o = taken_i AND the previous mask.
- R5: When the top record's next PC equals its merge PC and depth_o is above 1, pc_valid_o is 0 for that cycle. The next cycle drops one record. After the taken group finishes, this shows pc_o = fall_pc_i and mask_o = the not-taken threads of the divergent branch.
- R6: When the not-taken group also reaches the merge PC and is dropped, pc_o equals that merge PC and mask_o equals the mask held before the divergence.
- R7: A step presented while pc_valid_o is 0 has no effect. The stack state after the drop is the same as if no step had been presented.
- R8: If a divergent branch would need more than DEPTH records, overflow_o goes to 1 and stays at 1 until reset, and pc_o, mask_o and depth_o keep their values.
- R9: The bottom record is never dropped. At depth 1, pc_valid_o stays 1.
- R10: With step_valid_i low, pc_o, mask_o and depth_o hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_valid_i | input | 1 | One instruction at pc_o retires this cycle |
| is_branch_i | input | 1 | The retiring instruction is a conditional branch |
| taken_i | input | THREADS | Per-thread branch direction, 1 = taken |
| taken_pc_i | input | PC_W | Branch target |
| fall_pc_i | input | PC_W | Fall-through PC |
| reconv_pc_i | input | PC_W | PC where the two paths merge |
| pc_o | output | PC_W | Current warp PC |
| mask_o | output | THREADS | Current active-thread mask |
| pc_valid_o | output | 1 | Low in the bubble cycle of a record drop |
| depth_o | output | $clog2(DEPTH+1) | Number of records on the stack |
| overflow_o | output | 1 | Sticky stack overflow flag |

## Verification
The bench builds the block with four threads, 16-bit PCs and a depth of five. With these values two levels of nested divergence fit (depths 1, 3 and 5), and a third split overflows after only a few directed steps. A behavioural model held in queues runs alongside and is compared every cycle. Random branches are placed so that nested merge points coincide with outer ones, which brings back-to-back record drops into reach.

// File: rtl/simt_pkg.sv
package simt_pkg;

    typedef enum logic [1:0] {
        BK_LINEAR     = 2'd0,
        BK_ALL_TAKEN  = 2'd1,
        BK_NONE_TAKEN = 2'd2,
        BK_SPLIT      = 2'd3
    } br_kind_e;

endpackage

// File: rtl/simt_branch_split.sv
module simt_branch_split
    import simt_pkg::*;
#(
    parameter int THREADS = 4
) (
    input  logic               is_branch,
    input  logic [THREADS-1:0] act_mask,
    input  logic [THREADS-1:0] taken,
    output logic [THREADS-1:0] tk_mask,
    output logic [THREADS-1:0] nt_mask,
    output br_kind_e           kind
);

    always_comb begin
        tk_mask = act_mask & taken;
        nt_mask = act_mask & ~taken;
        if (!is_branch)
            kind = BK_LINEAR;
        else if (nt_mask == '0)
            kind = BK_ALL_TAKEN;
        else if (tk_mask == '0)
            kind = BK_NONE_TAKEN;
        else
            kind = BK_SPLIT;
    end

endmodule

// File: rtl/simt_entry_file.sv
module simt_entry_file #(
    parameter int          DEPTH    = 8,
    parameter int          PC_W     = 16,
    parameter int          THREADS  = 4,
    parameter logic [15:0] RESET_PC = 16'h0100,
    localparam int         SP_W     = $clog2(DEPTH),
    localparam int         EW       = 2 * PC_W + THREADS,
    localparam int         NWR      = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NWR-1:0]  we,
    input  logic [SP_W-1:0] waddr [NWR],
    input  logic [EW-1:0]   wdata [NWR],
    input  logic [SP_W-1:0] raddr,
    output logic [EW-1:0]   rdata
);

    localparam logic [EW-1:0] BASE_REC =
        {{PC_W{1'b1}}, PC_W'(RESET_PC), {THREADS{1'b1}}};

    logic [EW-1:0] slot_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[s] <= (s == 0) ? BASE_REC : '0;
            end else begin
                for (int p = 0; p < NWR; p++) begin
                    if (we[p] && waddr[p] == SP_W'(s))
                        slot_q[s] <= wdata[p];
                end
            end
        end
    end

    assign rdata = slot_q[raddr];

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_pkg::*;
#(
    parameter int          THREADS  = 4,
    parameter int          PC_W     = 16,
    parameter int          DEPTH    = 8,
    parameter logic [15:0] RESET_PC = 16'h0100,
    localparam int         SP_W     = $clog2(DEPTH),
    localparam int         DW       = $clog2(DEPTH + 1),
    localparam int         EW       = 2 * PC_W + THREADS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_valid_i,
    input  logic               is_branch_i,
    input  logic [THREADS-1:0] taken_i,
    input  logic [PC_W-1:0]    taken_pc_i,
    input  logic [PC_W-1:0]    fall_pc_i,
    input  logic [PC_W-1:0]    reconv_pc_i,
    output logic [PC_W-1:0]    pc_o,
    output logic [THREADS-1:0] mask_o,
    output logic               pc_valid_o,
    output logic [DW-1:0]      depth_o,
    output logic               overflow_o
);

    typedef struct packed {
        logic [SP_W-1:0] sp;
        logic            ovf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [2:0]         wr_en;
    logic [SP_W-1:0]    wr_addr [3];
    logic [EW-1:0]      wr_data [3];
    logic [EW-1:0]      top_rec;
    logic [PC_W-1:0]    top_rc, top_np;
    logic [THREADS-1:0] top_mk, tk_mask, nt_mask;
    br_kind_e           kind;
    logic               at_merge, accept, room;

    simt_entry_file #(
        .DEPTH(DEPTH), .PC_W(PC_W), .THREADS(THREADS), .RESET_PC(RESET_PC)
    ) u_file (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr),
        .wdata(wr_data), .raddr(ctl_q.sp), .rdata(top_rec)
    );

    assign top_rc = top_rec[EW-1 -: PC_W];
    assign top_np = top_rec[THREADS +: PC_W];
    assign top_mk = top_rec[THREADS-1:0];

    simt_branch_split #(.THREADS(THREADS)) u_split (
        .is_branch(is_branch_i), .act_mask(top_mk), .taken(taken_i),
        .tk_mask(tk_mask), .nt_mask(nt_mask), .kind(kind)
    );

    always_comb begin
        ctl_d    = ctl_q;
        wr_en    = '0;
        at_merge = (ctl_q.sp != '0) && (top_np == top_rc);
        accept   = step_valid_i && !at_merge;
        room     = ({1'b0, ctl_q.sp} + (SP_W + 1)'(2)) < (SP_W + 1)'(DEPTH);
        for (int p = 0; p < 3; p++) begin
            wr_addr[p] = ctl_q.sp + SP_W'(p);
            wr_data[p] = top_rec;
        end
        if (at_merge) begin
            ctl_d.sp = ctl_q.sp - SP_W'(1);
        end else if (accept) begin
            unique case (kind)
                BK_LINEAR: begin
                    wr_en[0]   = 1'b1;
                    wr_data[0] = {top_rc, top_np + PC_W'(1), top_mk};
                end
                BK_ALL_TAKEN: begin
                    wr_en[0]   = 1'b1;
                    wr_data[0] = {top_rc, taken_pc_i, top_mk};
                end
                BK_NONE_TAKEN: begin
                    wr_en[0]   = 1'b1;
                    wr_data[0] = {top_rc, fall_pc_i, top_mk};
                end
                default: begin
                    if (room) begin
                        wr_en      = 3'b111;
                        wr_data[0] = {top_rc, reconv_pc_i, top_mk};
                        wr_data[1] = {reconv_pc_i, fall_pc_i, nt_mask};
                        wr_data[2] = {reconv_pc_i, taken_pc_i, tk_mask};
                        ctl_d.sp   = ctl_q.sp + SP_W'(2);
                    end else begin
                        ctl_d.ovf = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign pc_o       = top_np;
    assign mask_o     = top_mk;
    assign pc_valid_o = !at_merge;
    assign depth_o    = DW'(ctl_q.sp) + DW'(1);
    assign overflow_o = ctl_q.ovf;

    AST_MASK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        mask_o != '0); // R4
    AST_SPLIT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid_i && pc_valid_o && kind == BK_SPLIT && !overflow_o && room)
        |=> depth_o == $past(depth_o) + DW'(2)); // R4
    AST_SPLIT_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid_i && pc_valid_o && kind == BK_SPLIT && room)
        |=> (mask_o & ~$past(mask_o)) == '0); // R4
    AST_UNIFORM_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid_i && pc_valid_o && (kind == BK_ALL_TAKEN || kind == BK_NONE_TAKEN))
        |=> $stable(depth_o) && $stable(mask_o)); // R3
    AST_BUBBLE_POPS: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_valid_o |=> depth_o == $past(depth_o) - DW'(1)); // R5
    AST_BASE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o == DW'(1) |-> pc_valid_o); // R9
    AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_valid_i && pc_valid_o) |=> $stable(pc_o) && $stable(depth_o)); // R10

endmodule

// File: tb/simt_reconv_stack_test.sv
module simt_reconv_stack_test;

    localparam int T = 4;
    localparam int PW = 16;
    localparam int DEP = 5;
    localparam int DW = $clog2(DEP + 1);
    localparam logic [15:0] RPC = 16'h0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_valid = 1'b0, is_branch = 1'b0;
    logic [T-1:0] taken = '0;
    logic [PW-1:0] tpc = '0, fpc = '0, rpc = '0;
    logic [PW-1:0] pc;
    logic [T-1:0] mask;
    logic pc_valid, ovf;
    logic [DW-1:0] depth;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    simt_reconv_stack #(.THREADS(T), .PC_W(PW), .DEPTH(DEP), .RESET_PC(RPC)) uut (
        .clk(clk), .rst_n(rst_n), .step_valid_i(step_valid), .is_branch_i(is_branch),
        .taken_i(taken), .taken_pc_i(tpc), .fall_pc_i(fpc), .reconv_pc_i(rpc),
        .pc_o(pc), .mask_o(mask), .pc_valid_o(pc_valid), .depth_o(depth),
        .overflow_o(ovf)
    );

    // behavioural model
    logic [PW-1:0] m_rc[$];
    logic [PW-1:0] m_np[$];
    logic [T-1:0]  m_mk[$];
    bit m_ovf;

    function automatic bit m_merge();
        return m_np.size() > 1 && m_np[$] == m_rc[$];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_rc = {16'hFFFF}; m_np = {RPC}; m_mk = {4'hF}; m_ovf = 0;
        end else if (m_merge()) begin
            void'(m_rc.pop_back()); void'(m_np.pop_back()); void'(m_mk.pop_back());
        end else if (step_valid) begin
            logic [T-1:0] tk, nt;
            tk = taken & m_mk[$];
            nt = ~taken & m_mk[$];
            if (!is_branch) m_np[$] = m_np[$] + 1;
            else if (nt == 0) m_np[$] = tpc;
            else if (tk == 0) m_np[$] = fpc;
            else if (m_np.size() + 2 > DEP) m_ovf = 1;
            else begin
                m_np[$] = rpc;
                m_rc.push_back(rpc); m_np.push_back(fpc); m_mk.push_back(nt);
                m_rc.push_back(rpc); m_np.push_back(tpc); m_mk.push_back(tk);
            end
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("model pc", 32'(pc), 32'(m_np[$]));
            chk("model mask", 32'(mask), 32'(m_mk[$]));
            chk("model depth", 32'(depth), 32'(m_np.size()));
            chk("model valid", 32'(pc_valid), 32'(!m_merge()));
            chk("model ovf", 32'(ovf), 32'(m_ovf));
        end
    end

    task automatic step(bit br, logic [T-1:0] tb, logic [PW-1:0] t, f, r);
        step_valid = 1; is_branch = br; taken = tb; tpc = t; fpc = f; rpc = r;
        @(negedge clk);
        step_valid = 0; is_branch = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 pc", 32'(pc), 32'h0100);
        chk("R1 mask", 32'(mask), 32'hF);
        chk("R1 depth", 32'(depth), 1);
        chk("R1 ovf", 32'(ovf), 0);
        chk("R1 valid", 32'(pc_valid), 1);
        step(0, 0, 0, 0, 0);
        chk("R2 pc", 32'(pc), 32'h0101);
        step(1, 4'hF, 16'h0200, 16'h0102, 16'h0300);
        chk("R3 taken pc", 32'(pc), 32'h0200);
        step(1, 4'h0, 16'h0250, 16'h0210, 16'h0300);
        chk("R3 fall pc", 32'(pc), 32'h0210);
        chk("R3 depth", 32'(depth), 1);
        @(negedge clk);
        chk("R10 pc", 32'(pc), 32'h0210);
        step(1, 4'b0110, 16'h0220, 16'h0230, 16'h0240);
        chk("R4 pc", 32'(pc), 32'h0220);
        chk("R4 mask", 32'(mask), 32'b0110);
        chk("R4 depth", 32'(depth), 3);
        step(1, 4'b1110, 16'h023F, 16'h0221, 16'h0240);
        chk("R3 inactive ignored", 32'(pc), 32'h023F);
        step(0, 0, 0, 0, 0);
        chk("R5 bubble", 32'(pc_valid), 0);
        step(0, 0, 0, 0, 0);
        chk("R5 pc", 32'(pc), 32'h0230);
        chk("R5 mask", 32'(mask), 32'b1001);
        chk("R7 depth", 32'(depth), 2);
        step(1, 4'hF, 16'h023F, 16'h0231, 16'h0240);
        step(0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R6 pc", 32'(pc), 32'h0240);
        chk("R6 mask", 32'(mask), 32'hF);
        chk("R6 depth", 32'(depth), 1);
        repeat (3) step(0, 0, 0, 0, 0);
        chk("R9 depth", 32'(depth), 1);
        chk("R9 valid", 32'(pc_valid), 1);
        step(1, 4'b0111, 16'h0300, 16'h0310, 16'h0320);
        step(1, 4'b0011, 16'h0301, 16'h0302, 16'h0303);
        chk("R4 nested depth", 32'(depth), 5);
        step(1, 4'b0001, 16'h0302, 16'h0303, 16'h0304);
        chk("R8 ovf", 32'(ovf), 1);
        chk("R8 pc", 32'(pc), 32'h0301);
        chk("R8 mask", 32'(mask), 32'b0011);
        chk("R8 depth", 32'(depth), 5);
        step(0, 0, 0, 0, 0);
        chk("R8 sticky", 32'(ovf), 1);
        for (int round = 0; round < 6; round++) begin
            do_reset();
            for (int c = 0; c < 500; c++) begin
                logic [PW-1:0] cur;
                bit br;
                cur = m_np[$];
                br = ($urandom_range(0, 2) == 0) &&
                     (m_np.size() == 1 || (m_rc[$] - cur) >= 3);
                if ($urandom_range(0, 4) == 0)
                    @(negedge clk);
                else
                    step(br, 4'($urandom_range(0, 15)), cur + 1, cur + 2, cur + 3);
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule